// File: doc/BRIEF.md
# Multi-Mode Capture Timer/Counter

This block is a pair of 8-bit counting halves that can work on their own or be joined into one 16-bit counter. Each half counts one of three things: ticks from a shared programmable prescaler, rising edges seen on an external count pin, or the carry out of the low half. A 2-bit mode value sets how the halves are grouped and what each one counts. In 8-bit form each half has its own capture register and its own match interrupt flag. In 16-bit form one trigger captures both bytes in the same cycle, and one 16-bit match drives the high flag.

Software programs the block through a small write-only register port. The port holds the mode, the prescaler reload value, a match value for each half, and a write-one-to-clear register for the flags. Captured counts and the two flags are plain outputs. There is no data stream, so the block has no valid/ready handshake. Every control input is sampled on each rising clock edge.

Top module: `cap_timer16`

## Requirements
- R1: While `rst` is high, and afterwards until the first write, the mode is 0, the prescaler reload is 0, both match registers are all ones, both counts are 0, both capture outputs are 0 and both flags are low.
- R2: A write with `wr_en` high selects a register by `wr_addr`: 0 = mode (`wr_data[1:0]`), 1 = prescaler reload, 2 = low match, 3 = high match, 4 = flag clear.
- R3: The prescaler issues one tick every reload+1 cycles. The first tick comes reload+1 cycles after a mode write.
- R4: Mode 0: both halves are independent 8-bit timers that advance on prescaler ticks.
- R5: Mode 1: the low half is a prescaled 8-bit timer. The high half counts external rising edges.
- R6: Mode 2: the halves form one 16-bit timer. The low byte advances on prescaler ticks and carries into the high byte when it passes 255.
- R7: Mode 3: the halves form one 16-bit counter of external rising edges.
- R8: `ext_cnt_in` passes through a two-flop synchronizer. Each rising edge adds exactly one count. The pin has no effect in modes 0 and 2.
- R9: A synchronized rising edge on a capture pin stores the count in the third clock edge after the pin is first sampled high. The stored value is the count held just before that edge. In modes 0/1, `cap_lo_in` loads `cap_lo_q` and `cap_hi_in` loads `cap_hi_q`. In modes 2/3, `cap_lo_in` loads both bytes at once and `cap_hi_in` is ignored.
- R10: In modes 0/1, a half that is due to advance while equal to its match value goes to 0 instead and sets its flag. In modes 2/3, the 16-bit count equal to {high match, low match} goes to 0 and sets only `irq_hi`.
- R11: The flags are sticky. Writing register 4 with bit 0 = 1 clears `irq_lo` and with bit 1 = 1 clears `irq_hi`. A zero bit leaves its flag as it is.
- R12: Any write to the mode register clears both counts and the prescaler on the same edge, and counting resumes on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write data |
| ext_cnt_in | input | 1 | External count input, asynchronous |
| cap_lo_in | input | 1 | Low (or 16-bit) capture trigger, asynchronous |
| cap_hi_in | input | 1 | High capture trigger, asynchronous |
| cap_lo_q | output | 8 | Low capture register |
| cap_hi_q | output | 8 | High capture register |
| irq_lo | output | 1 | Low match flag |
| irq_hi | output | 1 | High (or 16-bit) match flag |

## Verification
The bench builds the block with its default 8-bit halves and 8-bit prescaler. With these values, a 16-bit carry from 0x00FF to 0x0100 takes only about three hundred cycles at a reload of 0. A reload of 255 holds the timers at zero while external pulses are counted, so the event paths and the ignored pin can be checked alone. Match values as small as 2 let wraps, sticky flags and selective clears be checked in a handful of pulses.

// File: rtl/cap_timer16_pkg.sv
package cap_timer16_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL     = 2'd0,
    MODE_TMR_EVT  = 2'd1,
    MODE_CASC_TMR = 2'd2,
    MODE_CASC_EVT = 2'd3
  } tmode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
  localparam logic [ADDR_W-1:0] A_MLO    = 3'd2;
  localparam logic [ADDR_W-1:0] A_MHI    = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR    = 3'd4;
endpackage

// File: rtl/ct_edge_sync.sv
module ct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sh[g] <= 1'b0;
        else if (g == 0) sh[g] <= async_in;
        else sh[g] <= sh[g-1];
      end
    end
  endgenerate

  // last stage only remembers the previous synchronized value
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [PS_W-1:0] reload,
  output logic            tick
);
  logic [PS_W-1:0] ps_cnt;

  assign tick = (ps_cnt == reload);

  always_ff @(posedge clk) begin
    if (rst || clr) ps_cnt <= '0;
    else if (tick)  ps_cnt <= '0;
    else            ps_cnt <= ps_cnt + 1'b1;
  end
endmodule

// File: rtl/ct_half.sv
module ct_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic         cmp_en,
  input  logic [W-1:0] match,
  output logic [W-1:0] cnt,
  output logic         carry,
  output logic         hit
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  assign carry = inc && (cnt == ALL_ONES);
  assign hit   = inc && cmp_en && (cnt == match);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (hit)   cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cap_timer16.sv
module cap_timer16
  import cap_timer16_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PS_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              ext_cnt_in,
  input  logic              cap_lo_in,
  input  logic              cap_hi_in,
  output logic [HALF_W-1:0] cap_lo_q,
  output logic [HALF_W-1:0] cap_hi_q,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int FULL_W = 2 * HALF_W;

  tmode_e            mode_q;
  logic [PS_W-1:0]   reload_q;
  logic [HALF_W-1:0] mlo_q, mhi_q;
  logic [HALF_W-1:0] cnt_lo, cnt_hi;
  logic              mode_wr, clr_wr;
  logic              tick, ext_rise, caplo_rise, caphi_rise;
  logic              split, inc_lo, inc_hi;
  logic              carry_lo, carry_hi, hit_lo, hit_hi, hit16, clr_cnt;
  logic              set_lo, set_hi;

  assign mode_wr = wr_en && (wr_addr == A_MODE);
  assign clr_wr  = wr_en && (wr_addr == A_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_DUAL;
      reload_q <= '0;
      mlo_q    <= '1;
      mhi_q    <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE:   mode_q   <= tmode_e'(wr_data[1:0]);
        A_RELOAD: reload_q <= wr_data[PS_W-1:0];
        A_MLO:    mlo_q    <= wr_data;
        A_MHI:    mhi_q    <= wr_data;
        default:  ;
      endcase
    end
  end

  ct_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst(rst), .clr(mode_wr), .reload(reload_q), .tick(tick)
  );

  ct_edge_sync #(.STAGES(2)) u_sync_ext (
    .clk(clk), .rst(rst), .async_in(ext_cnt_in), .rise(ext_rise)
  );
  ct_edge_sync #(.STAGES(2)) u_sync_clo (
    .clk(clk), .rst(rst), .async_in(cap_lo_in), .rise(caplo_rise)
  );
  ct_edge_sync #(.STAGES(2)) u_sync_chi (
    .clk(clk), .rst(rst), .async_in(cap_hi_in), .rise(caphi_rise)
  );

  assign split = ~mode_q[1];

  always_comb begin
    case (mode_q)
      MODE_DUAL:     begin inc_lo = tick;     inc_hi = tick;     end
      MODE_TMR_EVT:  begin inc_lo = tick;     inc_hi = ext_rise; end
      MODE_CASC_TMR: begin inc_lo = tick;     inc_hi = carry_lo; end
      default:       begin inc_lo = ext_rise; inc_hi = carry_lo; end
    endcase
  end

  assign hit16   = !split && inc_lo && ({cnt_hi, cnt_lo} == FULL_W'({mhi_q, mlo_q}));
  assign clr_cnt = mode_wr || hit16;

  ct_half #(.W(HALF_W)) u_lo (
    .clk(clk), .rst(rst), .clr(clr_cnt), .inc(inc_lo), .cmp_en(split),
    .match(mlo_q), .cnt(cnt_lo), .carry(carry_lo), .hit(hit_lo)
  );
  ct_half #(.W(HALF_W)) u_hi (
    .clk(clk), .rst(rst), .clr(clr_cnt), .inc(inc_hi), .cmp_en(split),
    .match(mhi_q), .cnt(cnt_hi), .carry(carry_hi), .hit(hit_hi)
  );

  assign set_lo = split && hit_lo;
  assign set_hi = split ? hit_hi : hit16;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lo <= 1'b0;
      irq_hi <= 1'b0;
    end else begin
      irq_lo <= (irq_lo && !(clr_wr && wr_data[0])) || set_lo;
      irq_hi <= (irq_hi && !(clr_wr && wr_data[1])) || set_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_lo_q <= '0;
      cap_hi_q <= '0;
    end else begin
      if (caplo_rise) cap_lo_q <= cnt_lo;
      if (split ? caphi_rise : caplo_rise) cap_hi_q <= cnt_hi;
    end
  end
endmodule

// File: rtl/cap_timer16_chk.sv
module cap_timer16_chk
  import cap_timer16_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [HALF_W-1:0] wr_data,
  input logic              cap_lo_in,
  input logic [HALF_W-1:0] cap_lo_q,
  input logic              irq_lo,
  input logic              irq_hi,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] cnt_hi
);
  AST_IRQ_LO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_lo && !(wr_en && wr_addr == A_CLR && wr_data[0])) |=> irq_lo); // R11
  AST_IRQ_HI_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_hi && !(wr_en && wr_addr == A_CLR && wr_data[1])) |=> irq_hi); // R11
  AST_LO_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_lo) |-> (cnt_lo == '0)); // R10
  AST_MODE_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_MODE) |=> (cnt_lo == '0 && cnt_hi == '0)); // R12
  AST_CAP_FROM_PIN: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap_lo_q) |-> ($past(cap_lo_in, 3) && !$past(cap_lo_in, 4))); // R9
endmodule

bind cap_timer16 cap_timer16_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .cap_lo_in(cap_lo_in), .cap_lo_q(cap_lo_q), .irq_lo(irq_lo), .irq_hi(irq_hi),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi)
);

// File: tb/cap_timer16_tb.sv
`timescale 1ns/1ps
module cap_timer16_tb;
  localparam int WD_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ext_cnt_in = 1'b0, cap_lo_in = 1'b0, cap_hi_in = 1'b0;
  logic [7:0] cap_lo_q, cap_hi_q;
  logic       irq_lo, irq_hi;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cap_timer16 u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_cnt_in(ext_cnt_in), .cap_lo_in(cap_lo_in), .cap_hi_in(cap_hi_in),
    .cap_lo_q(cap_lo_q), .cap_hi_q(cap_hi_q), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  reload;
    logic [7:0]  mlo;
    logic [7:0]  mhi;
    logic [15:0] wait_n;
    logic [7:0]  pulses;
    logic [7:0]  exp_lo;
    logic [7:0]  exp_hi;
  } vec_t;

  // capture lands on count after wait_n+2 edges past the mode write
  localparam vec_t VECS [9] = '{
    '{2'd0, 8'd3,   8'd6,   8'd255, 16'd40,  8'd0, 8'd3,    8'd10},   // R4 R3 R10
    '{2'd0, 8'd0,   8'd255, 8'd9,   16'd20,  8'd0, 8'd22,   8'd2},    // R4 R10
    '{2'd1, 8'd255, 8'd255, 8'd255, 16'd4,   8'd5, 8'd0,    8'd5},    // R5 R8
    '{2'd1, 8'd2,   8'd255, 8'd255, 16'd10,  8'd0, 8'd4,    8'd0},    // R5 R3
    '{2'd2, 8'd0,   8'd255, 8'd255, 16'd300, 8'd0, 8'h2E,   8'h01},   // R6 carry
    '{2'd2, 8'd0,   8'd0,   8'd1,   16'd300, 8'd0, 8'd45,   8'd0},    // R6 R10
    '{2'd3, 8'd0,   8'd255, 8'd255, 16'd4,   8'd7, 8'd7,    8'd0},    // R7
    '{2'd3, 8'd0,   8'd4,   8'd0,   16'd4,   8'd7, 8'd2,    8'd0},    // R7 R10
    '{2'd0, 8'd255, 8'd255, 8'd255, 16'd4,   8'd5, 8'd0,    8'd0}     // R8 ignored
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      ext_cnt_in = 1'b1; repeat (2) @(negedge clk);
      ext_cnt_in = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic capture(input bit lo, input bit hi);
    cap_lo_in = lo; cap_hi_in = hi;
    repeat (4) @(negedge clk);
    cap_lo_in = 1'b0; cap_hi_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(WD_CYCLES * 5.0);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cap_lo", cap_lo_q, 0);
    chk("R1 cap_hi", cap_hi_q, 0);
    chk("R1 irqs", {irq_hi, irq_lo}, 0);

    foreach (VECS[i]) begin
      wr(3'd1, VECS[i].reload);
      wr(3'd2, VECS[i].mlo);
      wr(3'd3, VECS[i].mhi);
      wr(3'd4, 8'h03);
      wr(3'd0, {6'd0, VECS[i].mode}); // R2 R12
      pulse_ext(int'(VECS[i].pulses));
      repeat (int'(VECS[i].wait_n)) @(negedge clk);
      cap_lo_in = 1'b1; cap_hi_in = 1'b1;
      repeat (4) @(negedge clk);
      chk($sformatf("R9 vec%0d lo", i), cap_lo_q, VECS[i].exp_lo);
      chk($sformatf("R9 vec%0d hi", i), cap_hi_q, VECS[i].exp_hi);
      cap_lo_in = 1'b0; cap_hi_in = 1'b0;
      repeat (4) @(negedge clk);
    end

    // cascaded event counter, 16-bit match 2: flags, stickiness, clears
    wr(3'd2, 8'd2); wr(3'd3, 8'd0); wr(3'd4, 8'h03); wr(3'd0, 8'd3);
    pulse_ext(3);
    chk("R10 casc irq_hi", irq_hi, 1);
    chk("R10 casc irq_lo stays low", irq_lo, 0);
    pulse_ext(1);
    chk("R11 sticky irq_hi", irq_hi, 1);
    wr(3'd4, 8'h01);
    @(negedge clk);
    chk("R11 zero bit keeps irq_hi", irq_hi, 1);
    wr(3'd4, 8'h02);
    @(negedge clk);
    chk("R11 clear irq_hi", irq_hi, 0);
    capture(1'b1, 1'b0);
    chk("R9 casc capture", {cap_hi_q, cap_lo_q}, 16'h0001);
    pulse_ext(1);
    capture(1'b0, 1'b1);
    chk("R9 cap_hi_in ignored in mode 3", {cap_hi_q, cap_lo_q}, 16'h0001);
    capture(1'b1, 1'b0);
    chk("R9 both bytes latched", {cap_hi_q, cap_lo_q}, 16'h0002);
    wr(3'd0, 8'd3);
    capture(1'b1, 1'b0);
    chk("R12 mode write clears", {cap_hi_q, cap_lo_q}, 16'h0000);

    // split flags: event half wraps at match 1
    wr(3'd1, 8'd255); wr(3'd2, 8'd255); wr(3'd3, 8'd1); wr(3'd4, 8'h03); wr(3'd0, 8'd1);
    pulse_ext(2);
    chk("R10 split irq_hi", irq_hi, 1);
    chk("R10 split irq_lo", irq_lo, 0);
    // mode 0 low half with match 3 at reload 0 wraps within 5 cycles
    wr(3'd1, 8'd0); wr(3'd2, 8'd3); wr(3'd4, 8'h03); wr(3'd0, 8'd0);
    repeat (8) @(negedge clk);
    chk("R4 R10 irq_lo set", irq_lo, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule